// File: doc/BRIEF.md
# SPI Transmit/Receive Byte FIFO Pair

This block sits between a register port and the serial shifter of a SPI master. Software pushes outgoing data through a 32-bit data-out register and pulls incoming data from a 32-bit data-in register. The shifter takes transmit bytes one at a time and delivers receive bytes one at a time. Each direction has an 8-byte FIFO. Each FIFO keeps five flags: full, empty, a threshold-based ready flag, sticky overflow and sticky underflow.

A word-length bit selects 1-byte or 4-byte register accesses. Words are little-endian, so the byte in bits 7:0 is the first on the wire. The two 3-bit thresholds are written in complementary form: for N-byte words the receive threshold is N-1 and the transmit threshold is 7-N. When the last transmit word of a transfer is short, software fills the unused lanes with all ones. A flush command bit empties both FIFOs and clears itself, so software can poll it.

Top module: `spi_fifo_pair`

## Requirements
- R1: After reset, the configuration reads as zero and the status register reads 0x046: transmit empty, transmit ready and receive empty are set, and every other flag is clear.
- R2: With the word-length bit (config bit 5) clear, a write to the data-out register (address 2) pushes bits 7:0 as one byte. The shifter sees the bytes on `tx_byte` in the order they were written, and `tx_take` advances to the next byte. `tx_avail` is high exactly when the transmit FIFO is not empty.
- R3: With config bit 5 set, a data-out write pushes four bytes, and bits 7:0 leave first. A read of the data-in register (address 3) pops four bytes, and the first byte received is returned in bits 7:0.
- R4: A data-out write that needs more bytes than the transmit FIFO has free is dropped. It leaves the FIFO contents unchanged and sets the sticky transmit overflow flag.
- R5: A data-in read that needs more bytes than the receive FIFO holds returns zero and pops nothing, and it sets the sticky receive underflow flag. A `tx_take` on an empty transmit FIFO sets transmit underflow. An `rx_push` into a full receive FIFO is dropped and sets receive overflow.
- R6: The status register (address 1) holds the transmit flags in bits 4:0 and the receive flags in bits 9:5. Within each group, from low bit to high, the order is full, empty, ready, overflow, underflow. Full means 8 bytes are held and empty means 0 bytes are held.
- R7: Receive ready is set when the fill level exceeds the receive threshold in config bits 26:24. Transmit ready is set when the free space exceeds the transmit threshold in config bits 30:28.
- R8: Writing config bit 9 as one arms a flush. The bit reads back as one for one cycle. After that it reads as zero, both FIFOs are empty and all sticky flags are clear.
- R9: When a push and a pop reach the same FIFO in the same cycle, each is accepted or refused on the fill level at the start of that cycle. The new level is the old level plus the bytes accepted in, minus the bytes accepted out.
- R10: With config bit 5 clear, a data-in read pops one byte, returns it in bits 7:0 and returns zero in bits 31:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops the receive FIFO when reg_addr is 3 |
| reg_addr | input | 2 | Register select: 0 config, 1 status, 2 data-out, 3 data-in |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the same cycle as the select |
| tx_byte | output | 8 | Byte at the head of the transmit FIFO |
| tx_avail | output | 1 | Transmit FIFO holds at least one byte |
| tx_take | input | 1 | Shifter consumes the head transmit byte |
| rx_byte | input | 8 | Byte arriving from the shifter |
| rx_push | input | 1 | Shifter delivers rx_byte |

## Verification
Register traffic and shifter traffic can hit the same FIFO in the same cycle. A data-out write can arrive while the shifter takes a byte, and a data-in read can arrive while the shifter delivers one. The bench provokes this by asserting both strobes on one edge. It does this against a full transmit FIFO, against a receive FIFO holding exactly one word, and against a receive FIFO holding one byte in word mode. It then judges the results from the flags and the byte order seen afterwards. The write must be refused while the pop still happens, the read must succeed while the push is kept, and a read refused on the old level must not be rescued by the byte arriving in the same cycle.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
    localparam int REG_W       = 32;
    localparam int THR_W       = 3;
    localparam int WORD4_BIT   = 5;
    localparam int FLUSH_BIT   = 9;
    localparam int RX_THR_LSB  = 24;
    localparam int TX_THR_LSB  = 28;

    localparam logic [1:0] ADDR_CFG  = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_TXD  = 2'd2;
    localparam logic [1:0] ADDR_RXD  = 2'd3;

    typedef struct packed {
        logic [THR_W-1:0] tx_thr;
        logic [THR_W-1:0] rx_thr;
        logic             word4;
        logic             flush;
    } cfg_t;

    // last field is the LSB: full=bit0 ... udf=bit4
    typedef struct packed {
        logic udf;
        logic ovf;
        logic ready;
        logic empty;
        logic full;
    } fifo_flags_t;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int DEPTH      = 8,
    parameter int PUSH_LANES = 4,
    parameter int POP_LANES  = 1,
    localparam int AW  = $clog2(DEPTH),
    localparam int LW  = $clog2(DEPTH + 1),
    localparam int PNW = $clog2(PUSH_LANES + 1),
    localparam int QNW = $clog2(POP_LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    push_req,
    input  logic [PNW-1:0]          push_n,
    input  logic [PUSH_LANES*8-1:0] push_data,
    input  logic                    pop_req,
    input  logic [QNW-1:0]          pop_n,
    output logic [POP_LANES*8-1:0]  head_data,
    output logic                    pop_ok,
    output logic [LW-1:0]           level,
    output logic                    ovf,
    output logic                    udf
);
    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         wr;
        logic [AW-1:0]         rd;
        logic [LW-1:0]         level;
        logic                  ovf;
        logic                  udf;
    } state_t;

    state_t        s_d, s_q;
    logic [LW-1:0] free_sp;
    logic          push_ok;

    always_comb begin
        s_d     = s_q;
        free_sp = LW'(DEPTH) - s_q.level;
        push_ok = push_req && (free_sp >= LW'(push_n));
        pop_ok  = pop_req && (s_q.level >= LW'(pop_n));
        if (push_ok) begin
            for (int i = 0; i < PUSH_LANES; i++) begin
                if (i < int'(push_n)) begin
                    s_d.mem[s_q.wr + AW'(i)] = push_data[i*8 +: 8];
                end
            end
            s_d.wr = s_q.wr + AW'(push_n);
        end
        if (pop_ok) begin
            s_d.rd = s_q.rd + AW'(pop_n);
        end
        s_d.level = s_q.level + (push_ok ? LW'(push_n) : '0)
                              - (pop_ok  ? LW'(pop_n)  : '0);
        if (push_req && !push_ok) s_d.ovf = 1'b1;
        if (pop_req && !pop_ok)   s_d.udf = 1'b1;
        if (clear) begin
            s_d.wr    = '0;
            s_d.rd    = '0;
            s_d.level = '0;
            s_d.ovf   = 1'b0;
            s_d.udf   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < POP_LANES; g++) begin : g_head
        assign head_data[g*8 +: 8] = s_q.mem[s_q.rd + AW'(g)];
    end

    assign level = s_q.level;
    assign ovf   = s_q.ovf;
    assign udf   = s_q.udf;
endmodule

// File: rtl/spi_fifo_flags.sv
module spi_fifo_flags
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter bit FREE_BASED = 1'b0,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic [LW-1:0]    level,
    input  logic [THR_W-1:0] thr,
    input  logic             ovf,
    input  logic             udf,
    output fifo_flags_t      flags
);
    logic rdy;

    if (FREE_BASED) begin : g_space
        logic [LW-1:0] space;
        assign space = LW'(DEPTH) - level;
        assign rdy   = space > LW'(thr);
    end else begin : g_fill
        assign rdy = level > LW'(thr);
    end

    assign flags.full  = (level == LW'(DEPTH));
    assign flags.empty = (level == '0);
    assign flags.ready = rdy;
    assign flags.ovf   = ovf;
    assign flags.udf   = udf;
endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [7:0]        tx_byte,
    output logic              tx_avail,
    input  logic              tx_take,
    input  logic [7:0]        rx_byte,
    input  logic              rx_push
);
    localparam int LANES = REG_W / 8;
    localparam int LW    = $clog2(DEPTH + 1);
    localparam int WNW   = $clog2(LANES + 1);

    cfg_t cfg_d, cfg_q;

    logic              cfg_wr, txd_wr, rxd_rd;
    logic [WNW-1:0]    word_n;
    logic [LW-1:0]     tx_level, rx_level;
    logic              tx_ovf, tx_udf, rx_ovf, rx_udf;
    logic              tx_pop_ok, rx_pop_ok;
    logic [REG_W-1:0]  rx_head;
    fifo_flags_t       tx_flags, rx_flags;

    assign cfg_wr = reg_wr && (reg_addr == ADDR_CFG);
    assign txd_wr = reg_wr && (reg_addr == ADDR_TXD);
    assign rxd_rd = reg_rd && (reg_addr == ADDR_RXD);
    assign word_n = cfg_q.word4 ? WNW'(LANES) : WNW'(1);

    always_comb begin
        cfg_d       = cfg_q;
        cfg_d.flush = 1'b0;
        if (cfg_wr) begin
            cfg_d.tx_thr = reg_wdata[TX_THR_LSB +: THR_W];
            cfg_d.rx_thr = reg_wdata[RX_THR_LSB +: THR_W];
            cfg_d.word4  = reg_wdata[WORD4_BIT];
            cfg_d.flush  = reg_wdata[FLUSH_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    spi_byte_fifo #(.DEPTH(DEPTH), .PUSH_LANES(LANES), .POP_LANES(1)) i_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cfg_q.flush),
        .push_req  (txd_wr),
        .push_n    (word_n),
        .push_data (reg_wdata),
        .pop_req   (tx_take),
        .pop_n     (1'b1),
        .head_data (tx_byte),
        .pop_ok    (tx_pop_ok),
        .level     (tx_level),
        .ovf       (tx_ovf),
        .udf       (tx_udf)
    );

    spi_byte_fifo #(.DEPTH(DEPTH), .PUSH_LANES(1), .POP_LANES(LANES)) i_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cfg_q.flush),
        .push_req  (rx_push),
        .push_n    (1'b1),
        .push_data (rx_byte),
        .pop_req   (rxd_rd),
        .pop_n     (word_n),
        .head_data (rx_head),
        .pop_ok    (rx_pop_ok),
        .level     (rx_level),
        .ovf       (rx_ovf),
        .udf       (rx_udf)
    );

    spi_fifo_flags #(.DEPTH(DEPTH), .FREE_BASED(1'b1)) i_txflags (
        .level (tx_level),
        .thr   (cfg_q.tx_thr),
        .ovf   (tx_ovf),
        .udf   (tx_udf),
        .flags (tx_flags)
    );

    spi_fifo_flags #(.DEPTH(DEPTH), .FREE_BASED(1'b0)) i_rxflags (
        .level (rx_level),
        .thr   (cfg_q.rx_thr),
        .ovf   (rx_ovf),
        .udf   (rx_udf),
        .flags (rx_flags)
    );

    assign tx_avail = !tx_flags.empty;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CFG: begin
                reg_rdata[TX_THR_LSB +: THR_W] = cfg_q.tx_thr;
                reg_rdata[RX_THR_LSB +: THR_W] = cfg_q.rx_thr;
                reg_rdata[WORD4_BIT]           = cfg_q.word4;
                reg_rdata[FLUSH_BIT]           = cfg_q.flush;
            end
            ADDR_STAT: reg_rdata = {{(REG_W-10){1'b0}}, rx_flags, tx_flags};
            ADDR_RXD: begin
                if (rx_pop_ok) begin
                    reg_rdata = cfg_q.word4 ? rx_head
                                            : {{(REG_W-8){1'b0}}, rx_head[7:0]};
                end
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_fifo_pair_chk.sv
module spi_fifo_pair_chk #(
    parameter int DEPTH = 8,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush_wr,
    input logic          txd_wr,
    input logic          rxd_rd,
    input logic          flush_q,
    input logic [LW-1:0] tx_level,
    input logic [LW-1:0] rx_level,
    input logic          tx_ovf,
    input logic          rx_udf,
    input logic [31:0]   reg_rdata
);
    assert_flush_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_wr |=> flush_q);

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_q && !flush_wr) |=> (!flush_q && tx_level == '0 && rx_level == '0
                                    && !tx_ovf && !rx_udf));

    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ovf && !flush_q) |=> tx_ovf);

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_wr && tx_level == LW'(DEPTH) && !flush_q) |=> tx_ovf);

    assert_level_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH)));

    assert_empty_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rxd_rd && rx_level == '0) |-> (reg_rdata == 32'd0));
endmodule

bind spi_fifo_pair spi_fifo_pair_chk #(.DEPTH(DEPTH)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_wr  (reg_wr && reg_addr == 2'd0 && reg_wdata[9]),
    .txd_wr    (reg_wr && reg_addr == 2'd2),
    .rxd_rd    (reg_rd && reg_addr == 2'd3),
    .flush_q   (cfg_q.flush),
    .tx_level  (tx_level),
    .rx_level  (rx_level),
    .tx_ovf    (tx_ovf),
    .rx_udf    (rx_udf),
    .reg_rdata (reg_rdata)
);

// File: tb/test_spi_fifo_pair.sv
module test_spi_fifo_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  tx_byte;
    logic        tx_avail;
    logic        tx_take = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_push = 1'b0;

    int checks = 0, failures = 0;
    logic [31:0] v;
    logic [7:0]  b;

    localparam logic [31:0] CFG_BYTE = 32'h6000_0000;
    localparam logic [31:0] CFG_WORD = 32'h3300_0020;
    localparam logic [31:0] FLUSH    = 32'h0000_0200;
    localparam logic [31:0] S_TXFULL = 32'h001, S_TXEMP = 32'h002, S_TXRDY = 32'h004,
                            S_TXOVF  = 32'h008, S_TXUDF = 32'h010, S_RXFULL = 32'h020,
                            S_RXEMP  = 32'h040, S_RXRDY = 32'h080, S_RXOVF = 32'h100,
                            S_RXUDF  = 32'h200;

    spi_fifo_pair i_spi_fifo_pair (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_byte(tx_byte), .tx_avail(tx_avail), .tx_take(tx_take),
        .rx_byte(rx_byte), .rx_push(rx_push)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic take(output logic [7:0] d);
        @(negedge clk); tx_take = 1'b1; #1 d = tx_byte;
        @(negedge clk); tx_take = 1'b0;
    endtask

    task automatic give(input logic [7:0] d);
        @(negedge clk); rx_push = 1'b1; rx_byte = d;
        @(negedge clk); rx_push = 1'b0;
    endtask

    task automatic do_flush(input logic [31:0] cfg);
        wr(2'd0, cfg | FLUSH);
    endtask

    task automatic t_reset;
        peek(2'd0, v); check("R1 cfg", v, 32'h0);
        peek(2'd1, v); check("R1 status", v, 32'h046);
        check("R1 tx_avail", {31'd0, tx_avail}, 32'd0);
    endtask

    task automatic t_byte_tx;
        wr(2'd0, CFG_BYTE);
        wr(2'd2, 32'hFFFF_FF11); wr(2'd2, 32'h0000_0022); wr(2'd2, 32'h0000_0033);
        check("R2 tx_avail", {31'd0, tx_avail}, 32'd1);
        peek(2'd1, v); check("R7 tx not ready free5", v & (S_TXRDY | S_TXEMP), 32'h0);
        take(b); check("R2 byte0", {24'd0, b}, 32'h11);
        take(b); check("R2 byte1", {24'd0, b}, 32'h22);
        take(b); check("R2 byte2", {24'd0, b}, 32'h33);
        check("R2 tx_avail drained", {31'd0, tx_avail}, 32'd0);
        peek(2'd1, v); check("R7 tx ready free8", v & (S_TXRDY | S_TXEMP), S_TXRDY | S_TXEMP);
    endtask

    task automatic t_word_overflow;
        do_flush(CFG_WORD);
        wr(2'd2, 32'h0403_0201);
        peek(2'd1, v); check("R7 tx ready free4 thr3", v & S_TXRDY, S_TXRDY);
        wr(2'd2, 32'h0807_0605);
        peek(2'd1, v); check("R6 tx full", v & (S_TXFULL | S_TXRDY | S_TXOVF), S_TXFULL);
        wr(2'd2, 32'hDEAD_BEEF);
        peek(2'd1, v); check("R4 tx ovf", v & (S_TXFULL | S_TXOVF), S_TXFULL | S_TXOVF);
        for (int i = 1; i <= 8; i++) begin
            take(b); check("R3 R4 byte order", {24'd0, b}, 32'(i));
        end
        peek(2'd1, v); check("R4 ovf sticky, empty", v & (S_TXEMP | S_TXOVF), S_TXEMP | S_TXOVF);
    endtask

    task automatic t_rx_word;
        do_flush(CFG_WORD);
        give(8'hA0); give(8'hB1); give(8'hC2);
        peek(2'd1, v); check("R7 rx not ready 3", v & S_RXRDY, 32'h0);
        give(8'hD3);
        peek(2'd1, v); check("R7 rx ready 4", v & S_RXRDY, S_RXRDY);
        rd(2'd3, v); check("R3 rx word", v, 32'hD3C2_B1A0);
    endtask

    task automatic t_rx_byte_and_faults;
        do_flush(CFG_BYTE);
        give(8'h5A);
        rd(2'd3, v); check("R10 rx byte", v, 32'h0000_005A);
        rd(2'd3, v); check("R5 empty read zero", v, 32'h0);
        take(b);
        peek(2'd1, v); check("R5 underflow flags", v & (S_RXUDF | S_TXUDF), S_RXUDF | S_TXUDF);
        for (int i = 0; i < 9; i++) give(8'(i));
        peek(2'd1, v); check("R5 R6 rx full ovf", v & (S_RXFULL | S_RXOVF), S_RXFULL | S_RXOVF);
        for (int i = 0; i < 8; i++) begin
            rd(2'd3, v); check("R10 rx byte order", v, 32'(i));
        end
        peek(2'd1, v); check("R6 rx empty", v & S_RXEMP, S_RXEMP);
    endtask

    task automatic t_flush;
        wr(2'd2, 32'h77); give(8'h66);
        @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = CFG_BYTE | FLUSH;
        @(negedge clk); reg_wr = 1'b0; reg_addr = 2'd0; #1 v = reg_rdata;
        check("R8 flush bit set", v, CFG_BYTE | FLUSH);
        peek(2'd0, v); check("R8 flush self-clear", v, CFG_BYTE);
        peek(2'd1, v); check("R8 status after flush", v, 32'h046);
    endtask

    task automatic t_same_cycle;
        do_flush(CFG_BYTE);
        for (int i = 1; i <= 8; i++) wr(2'd2, 32'(i));
        @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h99; tx_take = 1'b1;
        #1 b = tx_byte; check("R9 head during clash", {24'd0, b}, 32'h01);
        @(negedge clk); reg_wr = 1'b0; tx_take = 1'b0;
        peek(2'd1, v); check("R9 write refused, pop kept", v & (S_TXFULL | S_TXOVF), S_TXOVF);
        for (int i = 2; i <= 8; i++) begin
            take(b); check("R9 remaining order", {24'd0, b}, 32'(i));
        end
        check("R9 dropped byte absent", {31'd0, tx_avail}, 32'd0);

        do_flush(CFG_WORD);
        give(8'h10); give(8'h20); give(8'h30); give(8'h40);
        @(negedge clk); reg_rd = 1'b1; reg_addr = 2'd3; rx_push = 1'b1; rx_byte = 8'h50;
        #1 v = reg_rdata; check("R9 read with push", v, 32'h4030_2010);
        @(negedge clk); reg_rd = 1'b1; rx_byte = 8'h60;
        #1 v = reg_rdata; check("R9 read refused on old level", v, 32'h0);
        @(negedge clk); reg_rd = 1'b0; rx_push = 1'b0;
        peek(2'd1, v); check("R9 rx udf, not empty", v & (S_RXUDF | S_RXEMP), S_RXUDF);
        give(8'h70); give(8'h80);
        rd(2'd3, v); check("R9 pushes kept", v, 32'h8070_6050);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_byte_tx();
        t_word_overflow();
        t_rx_word();
        t_rx_byte_and_faults();
        t_flush();
        t_same_cycle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule